// File: doc/BRIEF.md
# Warp Divergence Reconvergence Stack

This block tracks which of the 32 lockstep threads of one warp are enabled, and where the warp resumes, as the warp meets conditional branches. Each branch presents a per-lane outcome vector together with three addresses: the branch destination, the next sequential address, and the join point where both sides of the branch meet again. Lanes that are disabled when the branch arrives take no part in the vote.

When every enabled lane agrees, the warp simply jumps or falls through and its lane set does not change. When the enabled lanes disagree, the warp first runs the fall-through side with only the lanes that did not branch. The block saves two frames on an internal stack. The first frame is the join frame: the join address with the full pre-branch lane set. The second is the deferred frame: the destination address with the branching lanes.

Whenever the warp address equals the join address stored in the top frame, that frame is popped and becomes the warp state. The first pop therefore starts the deferred side, and the second restores the whole warp at the join point. Between branches the surrounding pipeline advances the address with a step strobe.

Top module: `simt_reconv_stack`

## Requirements
- R1: After synchronous reset, `warp_pc` is START_PC (default 0x100), `active_mask` is all ones, `stack_empty` is 1, and `stack_full` and `ovf_err` are 0.
- R2: A branch on which all enabled lanes agree sets `warp_pc` in the next cycle to `br_target` if they all branch, or to `br_fallthru` if none branch. `active_mask` is unchanged and the stack is untouched.
- R3: A lane whose `active_mask` bit is 0 is ignored in the vote; bit i of `br_taken` belongs to lane i.
- R4: On a split branch, in the next cycle `warp_pc` is `br_fallthru` and `active_mask` is the old mask with the branching lanes cleared.
- R5: A split branch pushes the join frame (`br_reconv`, old mask) and then the deferred frame (`br_target`, branching lanes), both keyed by `br_reconv`. `stack_empty` drops to 0.
- R6: When the stack is not empty and `warp_pc` equals the top frame's join address, the top frame is popped on that clock edge. Its address and lane set become `warp_pc` and `active_mask`. The first pop after a split yields the deferred side; the second yields the join address with the full pre-branch mask.
- R7: In a cycle where a pop occurs, `br_valid` and `step_valid` are ignored.
- R8: The stack holds 8 frames and `stack_full` is 1 when all 8 are used. A split branch with fewer than two free frames sets `ovf_err`, which stays set until reset, and leaves `warp_pc`, `active_mask` and the stack unchanged.
- R9: With no pop and no branch, `step_valid` loads `step_pc` into `warp_pc` and leaves `active_mask` unchanged.
- R10: When `br_valid` and `step_valid` are both high and no pop occurs, the branch wins and `step_pc` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| br_valid | input | 1 | Branch strobe |
| br_taken | input | 32 | Per-lane branch outcome |
| br_target | input | 32 | Branch destination address |
| br_fallthru | input | 32 | Sequential address after the branch |
| br_reconv | input | 32 | Join address of the branch |
| step_valid | input | 1 | Non-branch advance strobe |
| step_pc | input | 32 | Address loaded on a step |
| warp_pc | output | 32 | Current warp address |
| active_mask | output | 32 | Enabled lanes |
| stack_full | output | 1 | All frames in use |
| stack_empty | output | 1 | No frames in use |
| ovf_err | output | 1 | Sticky push-overflow error |

## Verification
The assertions assume that `br_taken` marks at least one enabled lane differently from another enabled lane only on genuine splits. They also assume that the pipeline never asks for a pop with an empty stack, so the enabled-lane set can never become empty.

The stimulus keeps to this by always starting from the full mask, or from a mask built by earlier splits. It picks outcome vectors inside the live lanes whenever a split is intended. The sweep walks every single-lane split across all 32 lanes. It also nests splits to the full depth and unwinds them in order, so every push and pop is observed at the ports.

// File: rtl/simt_pkg.sv
package simt_pkg;

    localparam int unsigned WARP_LANES = 32;
    localparam int unsigned PC_BITS    = 32;

    typedef logic [WARP_LANES-1:0] lane_mask_t;
    typedef logic [PC_BITS-1:0]    pc_t;

    // One saved execution context on the divergence stack.
    typedef struct packed {
        pc_t        resume_pc;
        lane_mask_t lanes;
        pc_t        join_pc;
    } frame_t;

    typedef enum logic [1:0] {
        VOTE_NONE   = 2'd0,
        VOTE_ALL_NT = 2'd1,
        VOTE_ALL_TK = 2'd2,
        VOTE_SPLIT  = 2'd3
    } vote_t;

    function automatic vote_t classify(lane_mask_t tk, lane_mask_t nt);
        if (tk == '0 && nt == '0) return VOTE_NONE;
        if (tk == '0)             return VOTE_ALL_NT;
        if (nt == '0)             return VOTE_ALL_TK;
        return VOTE_SPLIT;
    endfunction

endpackage

// File: rtl/simt_lane_vote.sv
module simt_lane_vote
    import simt_pkg::*;
(
    input  lane_mask_t active,
    input  lane_mask_t taken,
    output lane_mask_t tk_lanes,
    output lane_mask_t nt_lanes,
    output vote_t      vote
);

    for (genvar g = 0; g < WARP_LANES; g++) begin : g_lane
        assign tk_lanes[g] = active[g] &  taken[g];
        assign nt_lanes[g] = active[g] & ~taken[g];
    end

    assign vote = classify(tk_lanes, nt_lanes);

endmodule

// File: rtl/simt_div_stack.sv
module simt_div_stack
    import simt_pkg::*;
#(
    parameter int unsigned DEPTH = 8
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   push2,
    input  frame_t frame_lo,
    input  frame_t frame_hi,
    input  logic   pop,
    output frame_t top,
    output logic   empty,
    output logic   full,
    output logic   room2
);

    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    frame_t             mem [DEPTH];
    logic [CNT_W-1:0]   cnt;
    logic [IDX_W-1:0]   lo_idx, hi_idx, top_idx;
    logic [CNT_W-1:0]   cnt_dec;

    assign cnt_dec = cnt - CNT_W'(1);
    assign lo_idx  = cnt[IDX_W-1:0];
    assign hi_idx  = lo_idx + IDX_W'(1);
    assign top_idx = cnt_dec[IDX_W-1:0];

    assign empty = (cnt == '0);
    assign full  = (cnt == CNT_W'(DEPTH));
    assign room2 = (cnt <= CNT_W'(DEPTH - 2));
    assign top   = mem[top_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (pop) begin
            cnt <= cnt_dec;
        end else if (push2) begin
            mem[lo_idx] <= frame_lo;
            mem[hi_idx] <= frame_hi;
            cnt         <= cnt + CNT_W'(2);
        end
    end

    AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (rst) pop |-> !empty); // R6
    AST_NO_OVERFLOW:  assert property (@(posedge clk) disable iff (rst) push2 |-> room2); // R8
    AST_FLAGS_EXCL:   assert property (@(posedge clk) disable iff (rst) !(empty && full)); // R8
    AST_PUSH_FILLS:   assert property (@(posedge clk) disable iff (rst) (push2 && !pop) |=> !empty); // R5

endmodule

// File: rtl/simt_reconv_stack.sv
module simt_reconv_stack
    import simt_pkg::*;
#(
    parameter int unsigned DEPTH    = 8,
    parameter logic [31:0] START_PC = 32'h0000_0100
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        br_valid,
    input  logic [31:0] br_taken,
    input  logic [31:0] br_target,
    input  logic [31:0] br_fallthru,
    input  logic [31:0] br_reconv,
    input  logic        step_valid,
    input  logic [31:0] step_pc,
    output logic [31:0] warp_pc,
    output logic [31:0] active_mask,
    output logic        stack_full,
    output logic        stack_empty,
    output logic        ovf_err
);

    pc_t        pc_q;
    lane_mask_t mask_q;
    logic       ovf_q;

    lane_mask_t tk_lanes, nt_lanes;
    vote_t      vote;
    frame_t     top, join_frame, defer_frame;
    logic       room2, pop_now, push_now;

    simt_lane_vote u_vote (
        .active   (mask_q),
        .taken    (br_taken),
        .tk_lanes (tk_lanes),
        .nt_lanes (nt_lanes),
        .vote     (vote)
    );

    assign join_frame  = '{resume_pc: br_reconv, lanes: mask_q,   join_pc: br_reconv};
    assign defer_frame = '{resume_pc: br_target, lanes: tk_lanes, join_pc: br_reconv};

    assign pop_now  = !stack_empty && (top.join_pc == pc_q);
    assign push_now = !pop_now && br_valid && (vote == VOTE_SPLIT) && room2;

    simt_div_stack #(.DEPTH(DEPTH)) u_stack (
        .clk      (clk),
        .rst      (rst),
        .push2    (push_now),
        .frame_lo (join_frame),
        .frame_hi (defer_frame),
        .pop      (pop_now),
        .top      (top),
        .empty    (stack_empty),
        .full     (stack_full),
        .room2    (room2)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q   <= START_PC;
            mask_q <= '1;
            ovf_q  <= 1'b0;
        end else if (pop_now) begin
            pc_q   <= top.resume_pc;
            mask_q <= top.lanes;
        end else if (br_valid) begin
            unique case (vote)
                VOTE_ALL_NT: pc_q <= br_fallthru;
                VOTE_ALL_TK: pc_q <= br_target;
                VOTE_SPLIT: begin
                    if (room2) begin
                        pc_q   <= br_fallthru;
                        mask_q <= nt_lanes;
                    end else begin
                        ovf_q  <= 1'b1;
                    end
                end
                default: ;
            endcase
        end else if (step_valid) begin
            pc_q <= step_pc;
        end
    end

    assign warp_pc     = pc_q;
    assign active_mask = mask_q;
    assign ovf_err     = ovf_q;

    AST_UNIFORM_MASK: assert property (@(posedge clk) disable iff (rst)
        (br_valid && !pop_now && (vote == VOTE_ALL_NT || vote == VOTE_ALL_TK)) |=> $stable(active_mask)); // R2
    AST_SPLIT_SUBSET: assert property (@(posedge clk) disable iff (rst)
        (br_valid && !pop_now && vote == VOTE_SPLIT && room2) |=>
        (((active_mask & ~$past(active_mask)) == '0) && (active_mask != $past(active_mask)))); // R4
    AST_SPLIT_PUSHES: assert property (@(posedge clk) disable iff (rst)
        (br_valid && !pop_now && vote == VOTE_SPLIT && room2) |=> !stack_empty); // R5
    AST_OVF_STICKY:   assert property (@(posedge clk) disable iff (rst) ovf_err |=> ovf_err); // R8
    AST_OVF_HOLDS:    assert property (@(posedge clk) disable iff (rst)
        (br_valid && !pop_now && vote == VOTE_SPLIT && !room2) |=> ($stable(active_mask) && $stable(warp_pc))); // R8
    AST_STEP_MASK:    assert property (@(posedge clk) disable iff (rst)
        (step_valid && !br_valid && !pop_now) |=> $stable(active_mask)); // R9
    AST_MASK_LIVE:    assert property (@(posedge clk) disable iff (rst) active_mask != '0); // R4

endmodule

// File: tb/tb_simt_reconv_stack.sv
module tb_simt_reconv_stack;

    logic        clk = 1'b0;
    logic        rst;
    logic        br_valid, step_valid;
    logic [31:0] br_taken, br_target, br_fallthru, br_reconv, step_pc;
    logic [31:0] warp_pc, active_mask;
    logic        stack_full, stack_empty, ovf_err;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    simt_reconv_stack dut (
        .clk(clk), .rst(rst),
        .br_valid(br_valid), .br_taken(br_taken), .br_target(br_target),
        .br_fallthru(br_fallthru), .br_reconv(br_reconv),
        .step_valid(step_valid), .step_pc(step_pc),
        .warp_pc(warp_pc), .active_mask(active_mask),
        .stack_full(stack_full), .stack_empty(stack_empty), .ovf_err(ovf_err)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic clear_in();
        br_valid = 0; step_valid = 0; br_taken = '0;
        br_target = '0; br_fallthru = '0; br_reconv = '0; step_pc = '0;
    endtask

    task automatic do_branch(logic [31:0] tk, logic [31:0] tg, logic [31:0] ft, logic [31:0] rc);
        br_valid = 1; br_taken = tk; br_target = tg; br_fallthru = ft; br_reconv = rc;
        @(negedge clk);
        clear_in();
    endtask

    task automatic do_step(logic [31:0] p);
        step_valid = 1; step_pc = p;
        @(negedge clk);
        clear_in();
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1; clear_in();
        repeat (3) @(negedge clk);
        rst = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 pc", warp_pc, 32'h100);
        chk("R1 mask", active_mask, 32'hFFFF_FFFF);
        chk("R1 empty", {31'b0, stack_empty}, 1);
        chk("R1 full", {31'b0, stack_full}, 0);
        chk("R1 ovf", {31'b0, ovf_err}, 0);

        // R9 step
        do_step(32'h104);
        chk("R9 pc", warp_pc, 32'h104);
        chk("R9 mask", active_mask, 32'hFFFF_FFFF);

        // R2 uniform taken and uniform not-taken
        do_branch(32'hFFFF_FFFF, 32'h200, 32'h108, 32'h280);
        chk("R2 tk pc", warp_pc, 32'h200);
        chk("R2 tk mask", active_mask, 32'hFFFF_FFFF);
        chk("R2 tk empty", {31'b0, stack_empty}, 1);
        do_branch(32'h0, 32'h900, 32'h204, 32'h280);
        chk("R2 nt pc", warp_pc, 32'h204);
        chk("R2 nt empty", {31'b0, stack_empty}, 1);

        // R10 branch beats step
        step_valid = 1; step_pc = 32'h500;
        do_branch(32'h0, 32'h900, 32'h300, 32'h380);
        chk("R10 pc", warp_pc, 32'h300);

        // R4 R5 split
        do_branch(32'h0000_FFFF, 32'h400, 32'h304, 32'h480);
        chk("R4 pc", warp_pc, 32'h304);
        chk("R4 mask", active_mask, 32'hFFFF_0000);
        chk("R5 empty", {31'b0, stack_empty}, 0);

        // R3 inactive lanes ignored
        do_branch(32'h0000_FFFF, 32'h700, 32'h308, 32'h790);
        chk("R3 nt pc", warp_pc, 32'h308);
        chk("R3 nt mask", active_mask, 32'hFFFF_0000);
        do_branch(32'hFFFF_00FF, 32'h320, 32'h30C, 32'h790);
        chk("R3 tk pc", warp_pc, 32'h320);
        chk("R3 tk mask", active_mask, 32'hFFFF_0000);

        // R6 pops: deferred side then join
        do_step(32'h480);
        chk("R6 at join", warp_pc, 32'h480);
        idle();
        chk("R6 defer pc", warp_pc, 32'h400);
        chk("R6 defer mask", active_mask, 32'h0000_FFFF);
        chk("R6 not empty", {31'b0, stack_empty}, 0);
        do_step(32'h480);
        idle();
        chk("R6 join pc", warp_pc, 32'h480);
        chk("R6 join mask", active_mask, 32'hFFFF_FFFF);
        chk("R6 empty", {31'b0, stack_empty}, 1);
        idle();
        chk("R6 no extra pop", warp_pc, 32'h480);

        // R7 pop wins over branch and step
        do_branch(32'hAAAA_AAAA, 32'h600, 32'h500, 32'h680);
        chk("R7 split mask", active_mask, 32'h5555_5555);
        do_step(32'h680);
        step_valid = 1; step_pc = 32'h999;
        do_branch(32'h5555_5555, 32'h900, 32'h904, 32'h980);
        chk("R7 pc", warp_pc, 32'h600);
        chk("R7 mask", active_mask, 32'hAAAA_AAAA);
        do_step(32'h680);
        idle();
        chk("R7 join mask", active_mask, 32'hFFFF_FFFF);
        chk("R7 empty", {31'b0, stack_empty}, 1);

        // R8 fill to depth, overflow, unwind
        for (int k = 0; k < 4; k++) begin
            do_branch(32'h1 << k, 32'h1000 + k*16, 32'h2000 + k*16, 32'h3000 + k*16);
            chk("R8 nest mask", active_mask, ~((32'h2 << k) - 1));
        end
        chk("R8 full", {31'b0, stack_full}, 1);
        chk("R8 ovf before", {31'b0, ovf_err}, 0);
        do_branch(32'h10, 32'h1040, 32'h2040, 32'h3040);
        chk("R8 ovf", {31'b0, ovf_err}, 1);
        chk("R8 pc held", warp_pc, 32'h2030);
        chk("R8 mask held", active_mask, 32'hFFFF_FFF0);
        chk("R8 still full", {31'b0, stack_full}, 1);
        for (int k = 3; k >= 0; k--) begin
            do_step(32'h3000 + k*16);
            idle();
            chk("R8 unwind defer pc", warp_pc, 32'h1000 + k*16);
            chk("R8 unwind defer mask", active_mask, 32'h1 << k);
            chk("R8 not full", {31'b0, stack_full}, 0);
            do_step(32'h3000 + k*16);
            idle();
            chk("R8 unwind join pc", warp_pc, 32'h3000 + k*16);
            chk("R8 unwind join mask", active_mask, ~((32'h1 << k) - 1));
        end
        chk("R8 empty", {31'b0, stack_empty}, 1);
        chk("R8 ovf sticky", {31'b0, ovf_err}, 1);

        do_reset();
        chk("R1 ovf cleared", {31'b0, ovf_err}, 0);

        // Sweep of single-lane splits over every lane (R4, R6)
        for (int i = 0; i < 32; i++) begin
            do_branch(32'h1 << i, 32'h8000 + i*4, 32'h4000, 32'h6000);
            chk("R4 sweep pc", warp_pc, 32'h4000);
            chk("R4 sweep mask", active_mask, ~(32'h1 << i));
            do_step(32'h6000);
            idle();
            chk("R6 sweep defer pc", warp_pc, 32'h8000 + i*4);
            chk("R6 sweep defer mask", active_mask, 32'h1 << i);
            do_step(32'h6000);
            idle();
            chk("R6 sweep join mask", active_mask, 32'hFFFF_FFFF);
            chk("R6 sweep empty", {31'b0, stack_empty}, 1);
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule